// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each step it takes an operation code, the current accumulator, a second operand byte, the current flag nibble and a 16-bit pointer pair. It computes a new accumulator value, new flags and a new pointer value. The operations are eight-bit add, add-with-carry, subtract and compare, the bitwise AND, OR and XOR, four single-bit accumulator rotates, and a 16-bit add of a register pair into the pointer pair.

A registered stage captures all three results on the clock edge where the step enable is high. With the enable low it holds its last values. The surrounding machine feeds the registered outputs back as the next step's inputs, or replaces them, as its decode logic decides. Instruction decode, memory access and a half-carry flag are outside this block.

Top module: `acc_alu_unit`

## Requirements
- R1: After a synchronous reset, `acc_o`, `flags_o` and `hl_o` all read zero. The flag nibble is {S, Z, P, C} from bit 3 down to bit 0.
- R2: Op codes: 0 ADD, 1 ADC, 2 SUB, 3 CMP, 4 AND, 5 OR, 6 XOR, 7 rotate-left-circular, 8 rotate-right-circular, 9 rotate-left-through-carry, 10 rotate-right-through-carry, 11 pair add. ADD writes `acc_i + opnd_i` modulo 256 and ignores the incoming C. ADC also adds the incoming C. For both, C is set on 8-bit overflow.
- R3: SUB writes `acc_i - opnd_i` modulo 256. C is set as a borrow, which happens exactly when `acc_i` is unsigned-less-than `opnd_i`.
- R4: CMP leaves the accumulator equal to `acc_i`. It sets the flags exactly as SUB would: Z when the operands are equal, and C when `acc_i` is below `opnd_i`.
- R5: AND, OR and XOR write the bitwise result and clear C.
- R6: For ADD, ADC, SUB, CMP, AND, OR and XOR, S is bit 7 of the computed value, Z is set when that value is zero, and P is set when it holds an even number of ones.
- R7: The circular rotates copy the outgoing bit into both C and the vacated bit. Rotating 0x85 left gives 0x0B with C set. All four rotates change only C, and S, Z and P keep their `flags_i` values.
- R8: The through-carry rotates move the outgoing bit into C and the old C into the vacated bit. Rotating 0x85 left with C clear gives 0x0A with C set.
- R9: Pair add writes `hl_i + pair_i` modulo 65536 to `hl_o` and sets C on 16-bit overflow. For example, 0x1000 + 0xF500 gives 0x0500 with C set. S, Z, P and the accumulator keep their input values. Every other op passes `hl_i` to `hl_o` unchanged.
- R10: While `en_i` is low, the three outputs keep their values whatever the other inputs do.
- R11: Op codes 12 to 15 pass `acc_i`, `flags_i` and `hl_i` through unchanged.
- R12: A 16-bit addition done as ADD on the low bytes and then ADC on the high bytes, with the C from the first step fed back, gives the correct 16-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Step enable; results are captured when high |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand byte |
| flags_i | input | 4 | Current flags {S, Z, P, C} |
| hl_i | input | 16 | Current pointer pair |
| pair_i | input | 16 | Register pair added into the pointer pair |
| acc_o | output | 8 | Registered accumulator result |
| flags_o | output | 4 | Registered flags {S, Z, P, C} |
| hl_o | output | 16 | Registered pointer pair result |

## Verification
The bench builds the block with its default eight-bit data width, so the pointer path is sixteen bits wide. At that width the random stimulus easily reaches every operand byte, both carry-in values and all sixteen op codes, including the four unused ones. The fixed examples also apply at this width: 0x85 through both left rotates, and the 0x1000 + 0xF500 pair overflow. The other corners are directed cases: compare with equal operands and with the accumulator below the operand, the two-step multi-byte add, and held outputs while the enable is low.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_CMP  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_ROLC = 4'd7,
        OP_RORC = 4'd8,
        OP_ROLT = 4'd9,
        OP_RORT = 4'd10,
        OP_PAIR = 4'd11
    } alu_op_t;

    typedef struct packed {
        logic s;
        logic z;
        logic p;
        logic c;
    } alu_flags_t;

    function automatic logic is_logic_op(alu_op_t op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_szp_op(alu_op_t op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_CMP) || is_logic_op(op);
    endfunction

    function automatic logic is_rot_op(alu_op_t op);
        return (op == OP_ROLC) || (op == OP_RORC) ||
               (op == OP_ROLT) || (op == OP_RORT);
    endfunction

endpackage

// File: rtl/acc_alu_flag_gen.sv
module acc_alu_flag_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val_i,
    output logic              sign_o,
    output logic              zero_o,
    output logic              par_o
);
    assign sign_o = val_i[DATA_W-1];
    assign zero_o = (val_i == '0);
    assign par_o  = ~(^val_i);
endmodule

// File: rtl/acc_alu_byte_core.sv
module acc_alu_byte_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_t           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_flags_t        fl_i,
    output logic [DATA_W-1:0] res_o,
    output alu_flags_t        fl_o
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]  ext;
    logic [DATA_W-1:0] val;
    logic              new_c;
    logic              s_w, z_w, p_w;

    always_comb begin
        ext   = '0;
        val   = a_i;
        new_c = fl_i.c;
        unique case (op_i)
            OP_ADD: begin
                ext   = {1'b0, a_i} + {1'b0, b_i};
                val   = ext[DATA_W-1:0];
                new_c = ext[DATA_W];
            end
            OP_ADC: begin
                ext   = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, fl_i.c};
                val   = ext[DATA_W-1:0];
                new_c = ext[DATA_W];
            end
            OP_SUB, OP_CMP: begin
                ext   = {1'b0, a_i} - {1'b0, b_i};
                val   = ext[DATA_W-1:0];
                new_c = ext[DATA_W];
            end
            OP_AND: begin val = a_i & b_i; new_c = 1'b0; end
            OP_OR:  begin val = a_i | b_i; new_c = 1'b0; end
            OP_XOR: begin val = a_i ^ b_i; new_c = 1'b0; end
            OP_ROLC: begin
                val   = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
                new_c = a_i[DATA_W-1];
            end
            OP_RORC: begin
                val   = {a_i[0], a_i[DATA_W-1:1]};
                new_c = a_i[0];
            end
            OP_ROLT: begin
                val   = {a_i[DATA_W-2:0], fl_i.c};
                new_c = a_i[DATA_W-1];
            end
            OP_RORT: begin
                val   = {fl_i.c, a_i[DATA_W-1:1]};
                new_c = a_i[0];
            end
            default: begin
                val   = a_i;
                new_c = fl_i.c;
            end
        endcase
    end

    acc_alu_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .val_i  (val),
        .sign_o (s_w),
        .zero_o (z_w),
        .par_o  (p_w)
    );

    always_comb begin
        res_o = (op_i == OP_CMP) ? a_i : val;
        fl_o  = fl_i;
        if (is_szp_op(op_i)) begin
            fl_o = '{s: s_w, z: z_w, p: p_w, c: new_c};
        end else if (is_rot_op(op_i)) begin
            fl_o.c = new_c;
        end
    end
endmodule

// File: rtl/acc_alu_pair_add.sv
module acc_alu_pair_add #(
    parameter int PAIR_W = 16
) (
    input  logic [PAIR_W-1:0] hl_i,
    input  logic [PAIR_W-1:0] pair_i,
    output logic [PAIR_W-1:0] sum_o,
    output logic              carry_o
);
    logic [PAIR_W:0] wide;
    assign wide    = {1'b0, hl_i} + {1'b0, pair_i};
    assign sum_o   = wide[PAIR_W-1:0];
    assign carry_o = wide[PAIR_W];
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [3:0]        flags_i,
    input  logic [PAIR_W-1:0] hl_i,
    input  logic [PAIR_W-1:0] pair_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [3:0]        flags_o,
    output logic [PAIR_W-1:0] hl_o
);
    alu_op_t           op;
    alu_flags_t        fl_in, core_fl, next_fl;
    logic [DATA_W-1:0] core_res;
    logic [PAIR_W-1:0] pair_sum;
    logic              pair_c;

    assign op    = alu_op_t'(op_i);
    assign fl_in = alu_flags_t'(flags_i);

    acc_alu_byte_core #(.DATA_W(DATA_W)) u_core (
        .op_i  (op),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .fl_i  (fl_in),
        .res_o (core_res),
        .fl_o  (core_fl)
    );

    acc_alu_pair_add #(.PAIR_W(PAIR_W)) u_pair (
        .hl_i    (hl_i),
        .pair_i  (pair_i),
        .sum_o   (pair_sum),
        .carry_o (pair_c)
    );

    always_comb begin
        next_fl = core_fl;
        if (op == OP_PAIR) next_fl.c = pair_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o   <= '0;
            flags_o <= '0;
            hl_o    <= '0;
        end else if (en_i) begin
            acc_o   <= core_res;
            flags_o <= next_fl;
            hl_o    <= (op == OP_PAIR) ? pair_sum : hl_i;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(acc_o) && $stable(flags_o) && $stable(hl_o)));

    assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i == 4'd3) |=> (acc_o == $past(acc_i)));

    assert_cmp_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i == 4'd3 && acc_i == opnd_i) |=> (flags_o[2] && !flags_o[0]));

    assert_logic_clears_c_R5: assert property (@(posedge clk) disable iff (rst)
        (en_i && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6)) |=> !flags_o[0]);

    assert_pair_only_c_R9: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i == 4'd11) |=>
        (flags_o[3:1] == $past(flags_i[3:1]) && acc_o == $past(acc_i)));

    assert_rot_only_c_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i >= 4'd7 && op_i <= 4'd10) |=>
        (flags_o[3:1] == $past(flags_i[3:1])));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i <= 4'd6 && op_i != 4'd3) |=> (flags_o[2] == (acc_o == '0)));

    assert_undef_pass_R11: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i >= 4'd12) |=>
        (acc_o == $past(acc_i) && flags_o == $past(flags_i) && hl_o == $past(hl_i)));
endmodule

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  acc_i = '0, opnd_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] hl_i = '0, pair_i = '0;
    logic [7:0]  acc_o;
    logic [3:0]  flags_o;
    logic [15:0] hl_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acc_alu_unit u_acc_alu_unit (
        .clk(clk), .rst(rst), .en_i(en_i), .op_i(op_i), .acc_i(acc_i),
        .opnd_i(opnd_i), .flags_i(flags_i), .hl_i(hl_i), .pair_i(pair_i),
        .acc_o(acc_o), .flags_o(flags_o), .hl_o(hl_o)
    );

    function automatic logic even_ones(logic [7:0] v);
        int cnt = 0;
        for (int i = 0; i < 8; i++) if (v[i]) cnt++;
        return (cnt % 2) == 0;
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2:       return "R3";
            4'd3:       return "R4";
            4'd4, 4'd5, 4'd6: return "R5";
            4'd7, 4'd8: return "R7";
            4'd9, 4'd10: return "R8";
            4'd11:      return "R9";
            default:    return "R11";
        endcase
    endfunction

    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [3:0] f, input logic [15:0] hl, input logic [15:0] pr,
                         output logic [7:0] ea, output logic [3:0] ef, output logic [15:0] ehl);
        int v;
        int cin;
        logic [7:0] r;
        cin = f[0] ? 1 : 0;
        ea = a; ef = f; ehl = hl;
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: begin
                case (op)
                    4'd0: begin v = int'(a) + int'(b); ef[0] = (v > 255); end
                    4'd1: begin v = int'(a) + int'(b) + cin; ef[0] = (v > 255); end
                    4'd4: begin v = int'(a & b); ef[0] = 1'b0; end
                    4'd5: begin v = int'(a | b); ef[0] = 1'b0; end
                    4'd6: begin v = int'(a ^ b); ef[0] = 1'b0; end
                    default: begin v = int'(a) - int'(b); ef[0] = (a < b); end
                endcase
                r = 8'(v & 255);
                ef[3] = r[7];
                ef[2] = (r == 8'd0);
                ef[1] = even_ones(r);
                if (op != 4'd3) ea = r;
            end
            4'd7:  begin ea = {a[6:0], a[7]}; ef[0] = a[7]; end
            4'd8:  begin ea = {a[0], a[7:1]}; ef[0] = a[0]; end
            4'd9:  begin ea = {a[6:0], f[0]}; ef[0] = a[7]; end
            4'd10: begin ea = {f[0], a[7:1]}; ef[0] = a[0]; end
            4'd11: begin
                v = int'(hl) + int'(pr);
                ehl = 16'(v & 65535);
                ef[0] = (v > 65535);
            end
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] f, input logic [15:0] hl, input logic [15:0] pr);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; flags_i = f; hl_i = hl; pair_i = pr; en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        en_i = 1'b0;
    endtask

    task automatic run_check(input string tag, input logic [3:0] op, input logic [7:0] a,
                             input logic [7:0] b, input logic [3:0] f,
                             input logic [15:0] hl, input logic [15:0] pr);
        logic [7:0] ea; logic [3:0] ef; logic [15:0] ehl;
        model(op, a, b, f, hl, pr, ea, ef, ehl);
        step(op, a, b, f, hl, pr);
        check(tag, "result", {acc_o, flags_o, hl_o, 4'h0}, {ea, ef, ehl, 4'h0});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  ra, rb;
        logic [3:0]  rop, rf;
        logic [15:0] rh, rp;
        logic [7:0]  lo_sum;
        logic        lo_c;
        void'($urandom(32'd7741));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "acc after reset", 32'(acc_o), 32'h0);
        check("R1", "flags after reset", 32'(flags_o), 32'h0);
        check("R1", "hl after reset", 32'(hl_o), 32'h0);

        // R7: rotate-left-circular of 0x85 gives 0x0B, C set, S/Z/P kept
        step(4'd7, 8'h85, 8'h00, 4'b1010, 16'h1234, 16'h0);
        check("R7", "rlc acc", 32'(acc_o), 32'h0B);
        check("R7", "rlc flags", 32'(flags_o), 32'hB);
        // R8: rotate-left-through-carry of 0x85 with C clear gives 0x0A, C set
        step(4'd9, 8'h85, 8'h00, 4'b0000, 16'h0, 16'h0);
        check("R8", "ral acc", 32'(acc_o), 32'h0A);
        check("R8", "ral flags", 32'(flags_o), 32'h1);
        // R9: pair add 0x1000 + 0xF500
        step(4'd11, 8'h5A, 8'h00, 4'b1110, 16'h1000, 16'hF500);
        check("R9", "pair hl", 32'(hl_o), 32'h0500);
        check("R9", "pair flags", 32'(flags_o), 32'hF);
        check("R9", "pair acc", 32'(acc_o), 32'h5A);
        // R4: compare equal and less
        step(4'd3, 8'h42, 8'h42, 4'b0001, 16'h0, 16'h0);
        check("R4", "cmp eq acc", 32'(acc_o), 32'h42);
        check("R4", "cmp eq flags", 32'(flags_o), 32'h6);
        step(4'd3, 8'h10, 8'h20, 4'b0000, 16'h0, 16'h0);
        check("R4", "cmp lt acc", 32'(acc_o), 32'h10);
        check("R4", "cmp lt flags", 32'(flags_o), 32'hB);
        // R12: 0x12F0 + 0x0E30 via ADD then ADC
        step(4'd0, 8'hF0, 8'h30, 4'b0000, 16'h0, 16'h0);
        lo_sum = acc_o;
        lo_c = flags_o[0];
        check("R12", "low byte", 32'(lo_sum), 32'h20);
        step(4'd1, 8'h12, 8'h0E, {3'b000, lo_c}, 16'h0, 16'h0);
        check("R12", "high byte", 32'(acc_o), 32'h21);
        check("R12", "high carry", 32'(flags_o[0]), 32'h0);
        // R10: enable low holds outputs
        @(negedge clk);
        op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'h01; flags_i = 4'hF; hl_i = 16'hBEEF;
        en_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "hold", {acc_o, flags_o, hl_o, 4'h0}, {8'h21, 4'h2, 16'h0000, 4'h0});
        // R11: undefined code passes through
        step(4'd13, 8'hC3, 8'h11, 4'b0101, 16'hABCD, 16'h1111);
        check("R11", "undefined", {acc_o, flags_o, hl_o, 4'h0}, {8'hC3, 4'h5, 16'hABCD, 4'h0});
        // R2: ADD ignores carry-in
        run_check("R2", 4'd0, 8'hFF, 8'h01, 4'b0001, 16'h0, 16'h0);
        // R3: SUB borrow
        run_check("R3", 4'd2, 8'h05, 8'h06, 4'b0000, 16'h0, 16'h0);
        // R6: even parity of zero result from XOR
        run_check("R6", 4'd6, 8'hA5, 8'hA5, 4'b0001, 16'h0, 16'h0);

        for (int i = 0; i < 3000; i++) begin
            rop = 4'($urandom_range(0, 15));
            ra = 8'($urandom); rb = 8'($urandom);
            rf = 4'($urandom);
            rh = 16'($urandom); rp = 16'($urandom);
            run_check(tag_of(rop), rop, ra, rb, rf, rh, rp);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule